// File: doc/BRIEF.md
# Image Sensor Bring-Up and Identity Check Sequencer

This block brings an image sensor out of power-up in a controlled order. Right after its own reset it turns on the sensor clock enable, so the sensor's internal PLL has a clock while the sensor is still held in reset. It then keeps the sensor's active-low reset asserted for a programmed number of cycles, releases it, and waits a second programmed interval. This interval gives the sensor time to settle before any control access reaches it. At the usual rates both intervals are a few milliseconds. The defaults assume a 50 MHz block clock and give 3 ms each.

Once the second interval has passed, the sequencer asks an external serial control bus master to read one identification register from the sensor. It uses a one-cycle start pulse and holds a fixed device address and register address. When the master signals completion, the returned byte is captured and compared with the value a genuine sensor reports. The outcome is shown on sticky status outputs: finished with a matching identity, finished with a wrong identity, or stopped on a bus error when the master reports that the sensor gave no response. Only a fresh reset of the block restarts the sequence.

Top module: `cam_bringup_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the outputs after that edge are `sensor_rst_n`=0, `sensor_clk_en`=0, `bus_start`=0, and `seq_done`=`id_match`=`id_mismatch`=`seq_error`=0. This holds whatever state the block was in before.
- R2: `sensor_clk_en` goes high at the first clock edge with `rst_n` high. It then stays high until the next reset.
- R3: Once `sensor_clk_en` rises, `sensor_rst_n` stays low for exactly HOLD_CYCLES clock cycles and then goes high. It stays high until the next reset.
- R4: If `bus_busy` is low, `bus_start` is a single-cycle pulse. It is asserted exactly WAIT_CYCLES cycles after `sensor_rst_n` rises, and it is issued only once per sequence.
- R5: If `bus_busy` is high when the wait ends, the start is deferred. `bus_start` is asserted one cycle after the first edge at which `bus_busy` is sampled low.
- R6: While `bus_start` is high, the outputs are `bus_rd`=1, `bus_dev_id`=0x60, `bus_reg_addr`=0x0A and `bus_wdata`=0x00.
- R7: Suppose `bus_done` is sampled high with `bus_nack`=0 while a response is awaited, and `bus_rdata`=0x26. Then `seq_done` and `id_match` rise two cycles after that edge, and `id_mismatch` stays 0.
- R8: In the same situation with any other `bus_rdata`, `seq_done` and `id_mismatch` rise two cycles later and `id_match` stays 0. `id_match` and `id_mismatch` are never both high.
- R9: If `bus_done` is sampled high with `bus_nack`=1 while a response is awaited, `seq_error` rises one cycle later. `seq_done`, `id_match` and `id_mismatch` stay 0, and only a reset clears `seq_error`.
- R10: A `bus_done` pulse before `bus_start` has been issued is ignored. No status output changes, and the start timing of R4 is unchanged.
- R11: After `seq_done` is high, further `bus_done` pulses change no output, and `bus_start` is not asserted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset of the block |
| sensor_rst_n | output | 1 | Active-low reset driven to the sensor |
| sensor_clk_en | output | 1 | Enable for the sensor system clock generator |
| bus_start | output | 1 | One-cycle request pulse to the serial bus master |
| bus_rd | output | 1 | Transfer direction, 1 = read |
| bus_dev_id | output | 8 | Device address byte for the transfer |
| bus_reg_addr | output | 8 | Sensor register address for the transfer |
| bus_wdata | output | 8 | Write data (unused for reads, held at 0) |
| bus_busy | input | 1 | Bus master is occupied and cannot accept a request |
| bus_done | input | 1 | Single-cycle completion pulse from the bus master |
| bus_nack | input | 1 | Qualifies `bus_done`: the sensor did not respond |
| bus_rdata | input | 8 | Byte read back, valid with `bus_done` |
| seq_done | output | 1 | Identification read finished normally (sticky) |
| id_match | output | 1 | Read byte equals the expected identity (sticky) |
| id_mismatch | output | 1 | Read byte differs from the expected identity (sticky) |
| seq_error | output | 1 | Bus master reported no response (sticky) |

## Verification
A timing counter that is off by one moves the release of `sensor_rst_n`, or the `bus_start` pulse, by a cycle. A per-cycle comparison from reset release onward shows this in the very cycle it happens. If the sequencer is in the wrong state when a completion arrives, the problem surfaces two cycles later. It can show as a wrong or missing status flag, as a start pulse that repeats, or as a flag raised by a stray completion that should have been ignored. Sweeping every possible read-back byte, together with varied busy and response latencies, means a fault in the capture or the comparison shows up as a flag error on the first byte value it affects.

// File: rtl/cam_seq_pkg.sv
// Package: shared types for the sensor bring-up sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package cam_seq_pkg;

    // Sequencer states, listed in the order they are visited.
    typedef enum logic [2:0] {
        ST_CLK_ON    = 3'd0,
        ST_RST_HOLD  = 3'd1,
        ST_POST_WAIT = 3'd2,
        ST_ID_READ   = 3'd3,
        ST_CHECK     = 3'd4,
        ST_DONE      = 3'd5,
        ST_ERROR     = 3'd6
    } seq_state_t;

    // Defaults: 3 ms at a 50 MHz block clock.
    localparam int unsigned DEF_HOLD_CYCLES = 150_000;
    localparam int unsigned DEF_WAIT_CYCLES = 150_000;

endpackage

// File: rtl/cam_delay_timer.sv
// Module: cam_delay_timer
// Counts cycles while 'run' is high and flags the final cycle of a
// LIMIT-cycle interval. After that point the count saturates, so 'expired'
// stays high for as long as 'run' remains high.
// Assumes: LIMIT >= 1. Dropping 'run' clears the count for the next use.
module cam_delay_timer #(
    parameter int unsigned LIMIT = 150_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    // Count up while running, saturate at the last cycle, clear when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // The interval is complete in its LIMIT-th running cycle.
    assign expired = run && (cnt_q == LAST);

    // Once expired, the flag persists until the run request is withdrawn.
    assert_sat_R3: assert property (@(posedge clk) disable iff (!rst_n)
        expired |=> (!run || expired));

endmodule

// File: rtl/cam_id_compare.sv
// Module: cam_id_compare
// Captures the byte returned by the bus master on 'capture' and compares the
// held byte with the expected identity value.
// Assumes: 'capture' is high only in the cycle where the read data is valid.
module cam_id_compare #(
    parameter logic [7:0] EXPECT = 8'h26
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       capture,
    input  logic [7:0] rdata,
    output logic       id_equal
);
    logic [7:0] byte_q;

    // Hold the returned byte until the next capture or reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_q <= '0;
        end else if (capture) begin
            byte_q <= rdata;
        end
    end

    // Compare the held byte with the expected identity.
    assign id_equal = (byte_q == EXPECT);

endmodule

// File: rtl/cam_seq_fsm.sv
// Module: cam_seq_fsm
// Control state machine. It enables the sensor clock, holds and then releases
// the sensor reset, waits, issues one read request, and turns the outcome
// into sticky status flags.
// Assumes: timers report expiry while their run input is high. The bus master
// pulses 'bus_done' for one cycle, with 'bus_nack' valid in that same cycle.
module cam_seq_fsm
    import cam_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hold_expired,
    input  logic wait_expired,
    input  logic bus_busy,
    input  logic bus_done,
    input  logic bus_nack,
    input  logic id_equal,
    output logic hold_run,
    output logic wait_run,
    output logic capture,
    output logic sensor_rst_n,
    output logic sensor_clk_en,
    output logic bus_start,
    output logic seq_done,
    output logic id_match,
    output logic id_mismatch,
    output logic seq_error
);
    seq_state_t state_q, state_d;
    logic clk_en_q, srst_q, start_q, done_q, match_q, mism_q, err_q;

    // Next-state selection. Each state moves forward only on its own event.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLK_ON:    state_d = ST_RST_HOLD;
            ST_RST_HOLD:  if (hold_expired) state_d = ST_POST_WAIT;
            ST_POST_WAIT: if (wait_expired && !bus_busy) state_d = ST_ID_READ;
            ST_ID_READ:   if (bus_done) state_d = bus_nack ? ST_ERROR : ST_CHECK;
            ST_CHECK:     state_d = ST_DONE;
            ST_DONE:      state_d = ST_DONE;
            ST_ERROR:     state_d = ST_ERROR;
            default:      state_d = ST_CLK_ON;
        endcase
    end

    // State register and registered outputs, all set on state transitions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_CLK_ON;
            clk_en_q <= 1'b0;
            srst_q   <= 1'b0;
            start_q  <= 1'b0;
            done_q   <= 1'b0;
            match_q  <= 1'b0;
            mism_q   <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            start_q <= 1'b0;
            case (state_q)
                ST_CLK_ON:    clk_en_q <= 1'b1;
                ST_RST_HOLD:  if (hold_expired) srst_q <= 1'b1;
                ST_POST_WAIT: if (wait_expired && !bus_busy) start_q <= 1'b1;
                ST_ID_READ:   if (bus_done && bus_nack) err_q <= 1'b1;
                ST_CHECK: begin
                    done_q  <= 1'b1;
                    match_q <= id_equal;
                    mism_q  <= !id_equal;
                end
                default: ;
            endcase
        end
    end

    // Timer run requests and the capture strobe for the returned byte.
    assign hold_run = (state_q == ST_RST_HOLD);
    assign wait_run = (state_q == ST_POST_WAIT);
    assign capture  = (state_q == ST_ID_READ) && bus_done && !bus_nack;

    assign sensor_clk_en = clk_en_q;
    assign sensor_rst_n  = srst_q;
    assign bus_start     = start_q;
    assign seq_done      = done_q;
    assign id_match      = match_q;
    assign id_mismatch   = mism_q;
    assign seq_error     = err_q;

    assert_clk_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_q |=> clk_en_q);
    assert_release_clocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(srst_q) |-> clk_en_q);
    assert_start_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |-> srst_q);
    assert_start_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |=> !start_q);
    assert_start_not_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |-> !$past(bus_busy));
    assert_flag_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(match_q && mism_q));
    assert_error_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> (err_q && !done_q));
    assert_done_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> (done_q && !start_q));

endmodule

// File: rtl/cam_bringup_seq.sv
// Module: cam_bringup_seq (top)
// Sensor power-up sequencer. It enables the sensor clock, holds the sensor in
// reset for HOLD_CYCLES, waits WAIT_CYCLES, reads one identity register
// through an external serial bus master, and reports the result.
// Assumes: one clock domain shared with the bus master handshake. The bus
// master applies the read/write flag to the device address byte itself.
module cam_bringup_seq
    import cam_seq_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES = DEF_HOLD_CYCLES,
    parameter int unsigned WAIT_CYCLES = DEF_WAIT_CYCLES,
    parameter logic [7:0]  ID_DEVICE   = 8'h60,
    parameter logic [7:0]  ID_REGISTER = 8'h0A,
    parameter logic [7:0]  ID_EXPECT   = 8'h26
) (
    input  logic       clk,
    input  logic       rst_n,
    output logic       sensor_rst_n,
    output logic       sensor_clk_en,
    output logic       bus_start,
    output logic       bus_rd,
    output logic [7:0] bus_dev_id,
    output logic [7:0] bus_reg_addr,
    output logic [7:0] bus_wdata,
    input  logic       bus_busy,
    input  logic       bus_done,
    input  logic       bus_nack,
    input  logic [7:0] bus_rdata,
    output logic       seq_done,
    output logic       id_match,
    output logic       id_mismatch,
    output logic       seq_error
);
    logic hold_run, wait_run, hold_expired, wait_expired;
    logic capture, id_equal;

    // Fixed request fields for the identity read.
    assign bus_rd       = 1'b1;
    assign bus_dev_id   = ID_DEVICE;
    assign bus_reg_addr = ID_REGISTER;
    assign bus_wdata    = 8'h00;

    cam_delay_timer #(.LIMIT(HOLD_CYCLES)) u_hold_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (hold_run),
        .expired (hold_expired)
    );

    cam_delay_timer #(.LIMIT(WAIT_CYCLES)) u_wait_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (wait_run),
        .expired (wait_expired)
    );

    cam_id_compare #(.EXPECT(ID_EXPECT)) u_id_compare (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture),
        .rdata    (bus_rdata),
        .id_equal (id_equal)
    );

    cam_seq_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .hold_expired  (hold_expired),
        .wait_expired  (wait_expired),
        .bus_busy      (bus_busy),
        .bus_done      (bus_done),
        .bus_nack      (bus_nack),
        .id_equal      (id_equal),
        .hold_run      (hold_run),
        .wait_run      (wait_run),
        .capture       (capture),
        .sensor_rst_n  (sensor_rst_n),
        .sensor_clk_en (sensor_clk_en),
        .bus_start     (bus_start),
        .seq_done      (seq_done),
        .id_match      (id_match),
        .id_mismatch   (id_mismatch),
        .seq_error     (seq_error)
    );

endmodule

// File: tb/cam_bringup_seq_bench.sv
// Bench: sweeps every read-back byte, plus busy and response latencies, stray
// completions and no-response cases, on a short-delay configuration.
module cam_bringup_seq_bench;
    localparam int HOLD = 5;
    localparam int WAIT = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_busy = 1'b0, bus_done = 1'b0, bus_nack = 1'b0;
    logic [7:0] bus_rdata = 8'h00;
    logic sensor_rst_n, sensor_clk_en, bus_start, bus_rd;
    logic [7:0] bus_dev_id, bus_reg_addr, bus_wdata;
    logic seq_done, id_match, id_mismatch, seq_error;

    int compared = 0;
    int mismatched = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    cam_bringup_seq #(.HOLD_CYCLES(HOLD), .WAIT_CYCLES(WAIT)) u_cam_bringup_seq (
        .clk(clk), .rst_n(rst_n),
        .sensor_rst_n(sensor_rst_n), .sensor_clk_en(sensor_clk_en),
        .bus_start(bus_start), .bus_rd(bus_rd), .bus_dev_id(bus_dev_id),
        .bus_reg_addr(bus_reg_addr), .bus_wdata(bus_wdata),
        .bus_busy(bus_busy), .bus_done(bus_done), .bus_nack(bus_nack),
        .bus_rdata(bus_rdata), .seq_done(seq_done), .id_match(id_match),
        .id_mismatch(id_mismatch), .seq_error(seq_error)
    );

    // One comparison; on a difference, print the requirement and both values.
    task automatic chk(input string tag, input string what, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // One full sequence, checked at every falling edge from reset release on.
    task automatic run_one(input logic [7:0] rd, input bit nk, input int b, input int d, input bit stray);
        int ks, kd, last;
        bit exp_done, exp_err;
        string ftag, stag;
        ks = HOLD + WAIT + ((b > 1) ? b : 1);
        kd = ks + d;
        last = kd + 8;
        @(negedge clk);
        rst_n = 1'b0; bus_done = 1'b0; bus_nack = 1'b0; bus_rdata = 8'h00;
        bus_busy = (b > 0);
        repeat (2) @(negedge clk);
        // R1: reset state
        chk("R1", "sensor_rst_n", sensor_rst_n, 0);
        chk("R1", "sensor_clk_en", sensor_clk_en, 0);
        chk("R1", "bus_start", bus_start, 0);
        chk("R1", "status", {seq_done, id_match, id_mismatch, seq_error}, 0);
        rst_n = 1'b1;
        for (int k = 1; k <= last; k++) begin
            @(negedge clk);
            exp_done = !nk && (k >= kd + 2);
            exp_err  = nk && (k >= kd + 1);
            stag = (b > 1) ? "R5" : "R4";
            if (k > kd + 4) begin
                ftag = "R11"; stag = "R11";
            end else if (stray && k < ks) begin
                ftag = "R10"; stag = "R10";
            end else if (nk) begin
                ftag = "R9";
            end else if (rd == 8'h26) begin
                ftag = "R7";
            end else begin
                ftag = "R8";
            end
            chk("R2", "sensor_clk_en", sensor_clk_en, 1);
            chk("R3", "sensor_rst_n", sensor_rst_n, (k >= HOLD + 1) ? 1 : 0);
            chk(stag, "bus_start", bus_start, (k == ks) ? 1 : 0);
            chk(ftag, "seq_done", seq_done, exp_done);
            chk(ftag, "id_match", id_match, exp_done && (rd == 8'h26));
            chk(ftag, "id_mismatch", id_mismatch, exp_done && (rd != 8'h26));
            chk(ftag, "seq_error", seq_error, exp_err);
            if (k == ks) begin
                // R6: request fields while the start pulse is high
                chk("R6", "bus_rd", bus_rd, 1);
                chk("R6", "bus_dev_id", bus_dev_id, 8'h60);
                chk("R6", "bus_reg_addr", bus_reg_addr, 8'h0A);
                chk("R6", "bus_wdata", bus_wdata, 8'h00);
            end
            bus_done = 1'b0;
            bus_nack = 1'b0;
            if (b > 0 && k == HOLD + WAIT + b - 1) bus_busy = 1'b0;
            if (k == kd) begin
                bus_done = 1'b1; bus_nack = nk; bus_rdata = rd;
            end
            if (stray && (k == 2 || k == HOLD + 2 || k == kd + 4)) begin
                bus_done = 1'b1; bus_rdata = 8'h26;
            end
        end
    endtask

    // Main sweep.
    initial begin
        for (int v = 0; v < 256; v++) begin
            run_one(8'(v), 1'b0, v % 4, v % 3, v[0]);
        end
        for (int b = 0; b < 4; b++) begin
            run_one(8'h26, 1'b1, b, b % 3, b[0]);
        end
        run_one(8'h26, 1'b0, 0, 0, 1'b1);
        run_one(8'h26, 1'b0, 3, 1, 1'b1);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150_000) @(posedge clk);
        if (!finished) begin
            compared++;
            mismatched++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule